// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block sits next to a small 8-bit CPU core. It turns eight hardware event inputs into six latched request bits, one per vector. Four inputs come from external pins, two from a serial unit and two from counter/timers. Software sees three registers through a simple select/write/read port.

- The request register can be polled and can be written, so software can raise or drop any request.
- The enable register holds one enable per request and a global enable.
- A 3-bit priority code picks the order in which simultaneous requests are served.

The core pulses an end-of-instruction strobe. If the global enable is on and an enabled request is pending at that strobe, the winner is granted and the global enable is dropped. The block then runs a cycle-counted acknowledge sequence:

1. It pushes the two program-counter bytes and the flag byte as stack strobes.
2. It reads the two-byte handler address from the vector location of that request, high byte first.
3. It presents a jump strobe with the handler address on the 58th clock after the sample edge.

A return-from-interrupt pulse turns the global enable back on.

Top module: `intc_vec`

## Requirements
- R1: After synchronous reset, all three registers read 0. `busy`, `push_stb`, `vec_rd` and `jump_stb` are 0.
- R2: Each source held high at a clock edge sets its request bit, and the bit stays set until it is cleared. The mapping is:
  - `ext_irq[i]` sets bit i, for i = 0..3.
  - `ser_rx` sets bit 3.
  - `ser_tx` and `tmr0` set bit 4.
  - `tmr1` sets bit 5.
- R3: With `reg_we` high, `reg_sel` picks the register to write: 0 = request (bits 5:0), 1 = enable (bits 5:0 are per-request enables, bit 7 is the global enable), 2 = priority code (bits 2:0).
  - `reg_rdata` returns the register picked by `reg_sel` one clock later. Bit 6 of the enable register, and all unused bits, read 0.
  - A write to the request register replaces its contents. A hardware set at the same edge still wins.
- R4: No grant happens while the global enable is 0 or no pending request is enabled. Pending bits stay readable for polling.
- R5: A grant happens only at an edge where `eoi` is high and no sequence is running.
- R6: The priority code c (0..5) serves requests in the order c, c+1, … wrapping after 5. Codes 6 and 7 behave as code 0.
- R7: On grant, the global enable is cleared. `pc_in` and `flags_in` are captured at that same edge.
- R8: Counting the grant edge as edge 0, `push_stb` is high for one clock after the following edges:
  - edge 16, with `push_data` = PC low byte;
  - edge 32, with `push_data` = PC high byte;
  - edge 48, with `push_data` = flags.
- R9: For granted request n, `vec_rd` is high for one clock after edge 49 with `vec_addr` = 2n, and after edge 53 with `vec_addr` = 2n+1.
  - `vec_rdata` must stay valid while the address is held. The bytes are taken at edges 52 and 57.
  - Bit n of the request register is cleared at edge 49, unless a hardware set of bit n lands on that edge.
- R10: After edge 58, `jump_stb` is high for one clock with `jump_addr` = {byte at 2n, byte at 2n+1}. `busy` is high from edge 0 to edge 58 and low after it.
- R11: Requests that arrive during a sequence stay latched. They are served only after `reti` has set the global enable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | 4 | External pin requests |
| ser_rx | input | 1 | Serial receive event |
| ser_tx | input | 1 | Serial transmit event |
| tmr0 | input | 1 | Timer 0 event |
| tmr1 | input | 1 | Timer 1 event |
| eoi | input | 1 | End-of-instruction sample strobe |
| reti | input | 1 | Return from interrupt, sets global enable |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| pc_in | input | 16 | Current program counter |
| flags_in | input | 8 | Current flag byte |
| vec_rdata | input | 8 | Vector memory read data |
| busy | output | 1 | Acknowledge sequence running |
| push_stb | output | 1 | Stack push strobe |
| push_data | output | 8 | Stack push byte |
| vec_rd | output | 1 | Vector read strobe |
| vec_addr | output | 16 | Vector read address |
| jump_stb | output | 1 | Handler jump strobe |
| jump_addr | output | 16 | Handler address |

## Verification
The clear of the granted request bit at edge 49 can fall in the same cycle as a fresh hardware set of that same bit. The bench provokes this by pulsing the matching source so that it is captured exactly at edge 49. It then reads the request register after the sequence and expects the bit to still be set. A second collision, a software write to the request register on the same edge as a pin event, is judged by reading back the register and expecting the pin's bit to survive the write.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NREQ = 6;
  localparam int IDW  = 3;
  localparam int DW   = 8;
  typedef logic [IDW-1:0] irq_id_t;
  typedef logic [NREQ-1:0] irq_vec_t;
endpackage

// File: rtl/intc_req_reg.sv
module intc_req_reg
  import intc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  irq_vec_t hw_set,
  input  logic     sw_we,
  input  irq_vec_t sw_data,
  input  logic     clr_en,
  input  irq_id_t  clr_id,
  output irq_vec_t req
);
  irq_vec_t clr_mask;
  irq_vec_t base;

  always_comb begin
    clr_mask = '0;
    if (clr_en) clr_mask[clr_id] = 1'b1;
    base = sw_we ? sw_data : req;
  end

  always_ff @(posedge clk) begin
    if (rst) req <= '0;
    else     req <= (base & ~clr_mask) | hw_set;
  end
endmodule

// File: rtl/intc_prio.sv
module intc_prio
  import intc_pkg::*;
(
  input  irq_vec_t   pend,
  input  logic [2:0] code,
  output logic       valid,
  output irq_id_t    win
);
  int first;
  int idx;

  always_comb begin
    valid = 1'b0;
    win   = '0;
    first = (int'(code) < NREQ) ? int'(code) : 0;
    idx   = 0;
    for (int k = 0; k < NREQ; k++) begin
      idx = first + k;
      if (idx >= NREQ) idx = idx - NREQ;
      if (!valid && pend[idx]) begin
        valid = 1'b1;
        win   = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/intc_ack_seq.sv
module intc_ack_seq
  import intc_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int VADDR_W   = 16,
  parameter int PUSH_CYC  = 48,
  parameter int FETCH_CYC = 9
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  irq_id_t            win_id,
  input  logic [PC_W-1:0]    pc,
  input  logic [DW-1:0]      flags,
  input  logic [DW-1:0]      vec_rdata,
  output logic               busy,
  output logic               push_stb,
  output logic [DW-1:0]      push_data,
  output logic               vec_rd,
  output logic [VADDR_W-1:0] vec_addr,
  output logic               clr_en,
  output irq_id_t            clr_id,
  output logic               jump_stb,
  output logic [PC_W-1:0]    jump_addr
);
  localparam int P1_AT   = PUSH_CYC / 3;
  localparam int P2_AT   = (2 * PUSH_CYC) / 3;
  localparam int P3_AT   = PUSH_CYC;
  localparam int V1_AT   = PUSH_CYC + 1;
  localparam int CH_AT   = PUSH_CYC + 4;
  localparam int V2_AT   = PUSH_CYC + 5;
  localparam int CL_AT   = PUSH_CYC + FETCH_CYC;
  localparam int JMP_AT  = PUSH_CYC + FETCH_CYC + 1;
  localparam int CNT_W   = $clog2(JMP_AT + 2);

  logic [CNT_W-1:0] cnt;
  irq_id_t          id_q;
  logic [PC_W-1:0]  pc_q;
  logic [DW-1:0]    fl_q;
  logic [DW-1:0]    hi_q;
  logic [DW-1:0]    lo_q;

  assign clr_en = busy && (cnt == CNT_W'(V1_AT));
  assign clr_id = id_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      cnt       <= '0;
      id_q      <= '0;
      pc_q      <= '0;
      fl_q      <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      push_stb  <= 1'b0;
      push_data <= '0;
      vec_rd    <= 1'b0;
      vec_addr  <= '0;
      jump_stb  <= 1'b0;
      jump_addr <= '0;
    end else begin
      push_stb <= 1'b0;
      vec_rd   <= 1'b0;
      jump_stb <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(1);
        id_q <= win_id;
        pc_q <= pc;
        fl_q <= flags;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(P1_AT)) begin
          push_stb  <= 1'b1;
          push_data <= pc_q[DW-1:0];
        end
        if (cnt == CNT_W'(P2_AT)) begin
          push_stb  <= 1'b1;
          push_data <= pc_q[PC_W-1:PC_W-DW];
        end
        if (cnt == CNT_W'(P3_AT)) begin
          push_stb  <= 1'b1;
          push_data <= fl_q;
        end
        if (cnt == CNT_W'(V1_AT)) begin
          vec_rd   <= 1'b1;
          vec_addr <= VADDR_W'({id_q, 1'b0});
        end
        if (cnt == CNT_W'(CH_AT)) hi_q <= vec_rdata;
        if (cnt == CNT_W'(V2_AT)) begin
          vec_rd   <= 1'b1;
          vec_addr <= VADDR_W'({id_q, 1'b1});
        end
        if (cnt == CNT_W'(CL_AT)) lo_q <= vec_rdata;
        if (cnt == CNT_W'(JMP_AT)) begin
          jump_stb  <= 1'b1;
          jump_addr <= PC_W'({hi_q, lo_q});
          busy      <= 1'b0;
          cnt       <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/intc_vec.sv
module intc_vec
  import intc_pkg::*;
#(
  parameter int PC_W      = 16,
  parameter int VADDR_W   = 16,
  parameter int PUSH_CYC  = 48,
  parameter int FETCH_CYC = 9
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         ext_irq,
  input  logic               ser_rx,
  input  logic               ser_tx,
  input  logic               tmr0,
  input  logic               tmr1,
  input  logic               eoi,
  input  logic               reti,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [7:0]         flags_in,
  input  logic [7:0]         vec_rdata,
  output logic               busy,
  output logic               push_stb,
  output logic [7:0]         push_data,
  output logic               vec_rd,
  output logic [VADDR_W-1:0] vec_addr,
  output logic               jump_stb,
  output logic [PC_W-1:0]    jump_addr
);
  localparam int SEQ_LEN = PUSH_CYC + FETCH_CYC + 1;
  localparam logic [1:0] SEL_REQ = 2'd0;
  localparam logic [1:0] SEL_EN  = 2'd1;
  localparam logic [1:0] SEL_PRI = 2'd2;

  irq_vec_t   hw_set;
  irq_vec_t   req;
  irq_vec_t   en_q;
  logic       gie;
  logic [2:0] pri_q;
  logic       win_valid;
  irq_id_t    win_id;
  logic       start;
  logic       clr_en;
  irq_id_t    clr_id;

  assign hw_set = {tmr1, ser_tx | tmr0, ext_irq[3] | ser_rx, ext_irq[2:0]};

  intc_req_reg u_req (
    .clk     (clk),
    .rst     (rst),
    .hw_set  (hw_set),
    .sw_we   (reg_we && reg_sel == SEL_REQ),
    .sw_data (reg_wdata[NREQ-1:0]),
    .clr_en  (clr_en),
    .clr_id  (clr_id),
    .req     (req)
  );

  intc_prio u_prio (
    .pend  (req & en_q),
    .code  (pri_q),
    .valid (win_valid),
    .win   (win_id)
  );

  assign start = eoi && gie && !busy && win_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      gie   <= 1'b0;
      pri_q <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_EN)  en_q  <= reg_wdata[NREQ-1:0];
      if (reg_we && reg_sel == SEL_PRI) pri_q <= reg_wdata[2:0];
      if (start)                            gie <= 1'b0;
      else if (reti)                        gie <= 1'b1;
      else if (reg_we && reg_sel == SEL_EN) gie <= reg_wdata[7];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_sel)
        SEL_REQ: reg_rdata <= {2'b00, req};
        SEL_EN:  reg_rdata <= {gie, 1'b0, en_q};
        SEL_PRI: reg_rdata <= {5'b0, pri_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  intc_ack_seq #(
    .PC_W      (PC_W),
    .VADDR_W   (VADDR_W),
    .PUSH_CYC  (PUSH_CYC),
    .FETCH_CYC (FETCH_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .win_id    (win_id),
    .pc        (pc_in),
    .flags     (flags_in),
    .vec_rdata (vec_rdata),
    .busy      (busy),
    .push_stb  (push_stb),
    .push_data (push_data),
    .vec_rd    (vec_rd),
    .vec_addr  (vec_addr),
    .clr_en    (clr_en),
    .clr_id    (clr_id),
    .jump_stb  (jump_stb),
    .jump_addr (jump_addr)
  );
endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk #(
  parameter int SEQ_LEN = 58
)(
  input logic clk,
  input logic rst,
  input logic eoi,
  input logic gie,
  input logic busy,
  input logic push_stb,
  input logic vec_rd,
  input logic jump_stb
);
  localparam int RW = $clog2(SEQ_LEN + 2);
  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= '0;
    else              run_len <= run_len + 1'b1;
  end

  // R10
  seq_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == RW'(SEQ_LEN));

  // R5
  eoi_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(eoi));

  // R7
  gie_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !gie);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_stb, vec_rd, jump_stb}));

  // R8
  push_busy_chk: assert property (@(posedge clk) disable iff (rst)
    push_stb |-> busy);

  // R10
  jump_end_chk: assert property (@(posedge clk) disable iff (rst)
    jump_stb |-> $fell(busy));

  // R4
  no_gie_chk: assert property (@(posedge clk) disable iff (rst)
    (!gie && !busy) |=> !busy);
endmodule

bind intc_vec intc_vec_chk #(.SEQ_LEN(SEQ_LEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .eoi      (eoi),
  .gie      (gie),
  .busy     (busy),
  .push_stb (push_stb),
  .vec_rd   (vec_rd),
  .jump_stb (jump_stb)
);

// File: tb/sim_intc_vec.sv
`timescale 1ns/1ps
module sim_intc_vec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ext_irq = '0;
  logic        ser_rx = 0, ser_tx = 0, tmr0 = 0, tmr1 = 0;
  logic        eoi = 0, reti = 0, reg_we = 0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] pc_in = '0;
  logic [7:0]  flags_in = '0;
  logic [7:0]  vec_rdata;
  logic        busy, push_stb, vec_rd, jump_stb;
  logic [7:0]  push_data;
  logic [15:0] vec_addr, jump_addr;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] vmem(input logic [15:0] a);
    return a[7:0] * 8'h1D + 8'h3C;
  endfunction

  assign vec_rdata = vmem(vec_addr);

  intc_vec u0 (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .tmr0(tmr0), .tmr1(tmr1), .eoi(eoi), .reti(reti), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pc_in(pc_in), .flags_in(flags_in), .vec_rdata(vec_rdata), .busy(busy),
    .push_stb(push_stb), .push_data(push_data), .vec_rd(vec_rd),
    .vec_addr(vec_addr), .jump_stb(jump_stb), .jump_addr(jump_addr)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // source bit layout: {tmr1, tmr0, ser_tx, ser_rx, ext_irq[3:0]}
  task automatic set_src(input logic [7:0] s);
    ext_irq = s[3:0]; ser_rx = s[4]; ser_tx = s[5]; tmr0 = s[6]; tmr1 = s[7];
  endtask

  function automatic logic [7:0] src_of(input int id);
    if (id < 4) return 8'(1 << id);
    if (id == 4) return 8'h20;
    return 8'h80;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    reg_sel = sel;
    tick();
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic pulse_src(input logic [7:0] s);
    set_src(s); tick(); set_src(8'h00);
  endtask

  task automatic pulse_reti();
    reti = 1; tick(); reti = 0;
  endtask

  task automatic eoi_no_ack(input string tag);
    eoi = 1; tick(); eoi = 0;
    check(busy == 0, tag, busy, 0);
    tick();
    check(busy == 0, tag, busy, 0);
  endtask

  task automatic run_ack(input int id, input logic [15:0] pc, input logic [7:0] fl,
                         input logic [7:0] inj);
    logic [15:0] ea;
    ea = {vmem(16'(2*id)), vmem(16'(2*id+1))};
    pc_in = pc; flags_in = fl; eoi = 1;
    tick();
    eoi = 0; pc_in = ~pc; flags_in = ~fl;
    for (int k = 1; k <= 60; k++) begin
      if (k == 49) set_src(inj);
      tick();
      set_src(8'h00);
      check(busy == (k < 58), "R10 busy window", busy, k < 58);
      check(push_stb == (k == 16 || k == 32 || k == 48), "R8 push strobe", push_stb, k);
      if (k == 16) check(push_data == pc[7:0], "R8 PC low push", push_data, pc[7:0]);
      if (k == 32) check(push_data == pc[15:8], "R8 PC high push", push_data, pc[15:8]);
      if (k == 48) check(push_data == fl, "R7 flags push", push_data, fl);
      check(vec_rd == (k == 49 || k == 53), "R9 vector strobe", vec_rd, k);
      if (k == 49) check(vec_addr == 16'(2*id), "R9 vector addr hi", vec_addr, 2*id);
      if (k == 53) check(vec_addr == 16'(2*id+1), "R9 vector addr lo", vec_addr, 2*id+1);
      check(jump_stb == (k == 58), "R10 jump strobe", jump_stb, k);
      if (k == 58) check(jump_addr == ea, "R10 jump addr", jump_addr, ea);
    end
  endtask

  task automatic t_reset();
    check(busy == 0 && push_stb == 0 && vec_rd == 0 && jump_stb == 0,
          "R1 outputs idle", {busy, push_stb, vec_rd, jump_stb}, 0);
    rd_chk(2'd0, 8'h00, "R1 request reset");
    rd_chk(2'd1, 8'h00, "R1 enable reset");
    rd_chk(2'd2, 8'h00, "R1 priority reset");
  endtask

  task automatic t_poll();
    pulse_src(8'h01); pulse_src(8'h10); pulse_src(8'h40);
    rd_chk(2'd0, 8'h19, "R2 ext0 ser_rx tmr0 latch");
    pulse_src(8'h08); pulse_src(8'h20); pulse_src(8'h80); pulse_src(8'h06);
    rd_chk(2'd0, 8'h3F, "R2 all bits latched");
    wr(2'd1, 8'h3F);
    eoi_no_ack("R4 global enable off");
    wr(2'd1, 8'h80);
    eoi_no_ack("R4 all masked");
    rd_chk(2'd0, 8'h3F, "R4 polled pending");
    wr(2'd1, 8'hFF);
    rd_chk(2'd1, 8'hBF, "R3 enable bit6 reads 0");
    tick();
    check(busy == 0, "R5 no eoi no grant", busy, 0);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    rd_chk(2'd0, 8'h00, "R3 software clear");
    reg_we = 1; reg_sel = 2'd0; reg_wdata = 8'h00; set_src(8'h01);
    tick();
    reg_we = 0; set_src(8'h00);
    rd_chk(2'd0, 8'h01, "R3 hw set beats write");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_sw_trigger();
    wr(2'd0, 8'h20);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hA0);
    run_ack(5, 16'h1234, 8'h5A, 8'h00);
    rd_chk(2'd0, 8'h00, "R9 granted bit cleared");
    rd_chk(2'd1, 8'h20, "R7 global enable cleared");
  endtask

  task automatic t_priority();
    pulse_src(8'h22);
    wr(2'd2, 8'h03);
    wr(2'd1, 8'hBF);
    run_ack(4, 16'hBEEF, 8'hC3, 8'h00);
    rd_chk(2'd0, 8'h02, "R6 code3 picked 4 first");
    pulse_reti();
    rd_chk(2'd1, 8'hBF, "R11 reti sets enable");
    run_ack(1, 16'h0F0F, 8'h11, 8'h00);
    pulse_src(8'h84);
    wr(2'd2, 8'h07);
    pulse_reti();
    run_ack(2, 16'hA55A, 8'h77, 8'h00);
    rd_chk(2'd0, 8'h20, "R6 fallback code left bit5");
    wr(2'd0, 8'h11);
    wr(2'd2, 8'h05);
    pulse_reti();
    run_ack(0, 16'h4321, 8'h09, 8'h00);
    rd_chk(2'd0, 8'h10, "R6 code5 wraps to 0");
    wr(2'd0, 8'h00);
  endtask

  task automatic t_latched();
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h00);
    pulse_reti();
    run_ack(0, 16'h2222, 8'h33, 8'h80);
    rd_chk(2'd0, 8'h20, "R11 request latched during ack");
    eoi_no_ack("R11 not served before reti");
    pulse_reti();
    run_ack(5, 16'h6666, 8'h44, 8'h00);
    rd_chk(2'd0, 8'h00, "R11 served after reti");
  endtask

  task automatic t_collide();
    pulse_src(8'h10);
    pulse_reti();
    run_ack(3, 16'h9876, 8'hE1, src_of(3));
    rd_chk(2'd0, 8'h08, "R9 hw set beats grant clear");
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_poll();
    t_sw_trigger();
    t_priority();
    t_latched();
    t_collide();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule